// File: doc/BRIEF.md
# GPIO Bank with Transition Interrupt

This block is one general-purpose I/O bank of `WIDTH` pins with its own small register set. Each pin can be an input or an output. An output pin works in one of two styles. In level style the pin follows a stored bit, optionally inverted. In pulse style, writing a 1 fires a single pulse of fixed width. Each output pin can be driven push-pull or open-drain, and the pad itself sits outside the block, which supplies only an output enable and a data value per pin.

Input pins pass through a two-stage synchroniser. Any edge on an input sets a sticky status bit, and the status register clears when it is read. When an enabled status bit is pending, a shared interrupt line is driven. That line is either held active (level style) or pulsed over and over (pulse style), in the polarity that software selects. An enabled interrupt can also clear a low-power flag, which serves as a wake-up. A read-only snapshot register holds the pin levels captured while reset was asserted.

Pulse widths come from the clock-frequency parameter. At the default 8 MHz, an output pulse lasts 4 cycles (0.5 µs) and an interrupt pulse lasts 2 cycles (0.25 µs).

Top module: `gpio_bank_irq`

## Requirements
- R1: The reset state is as follows. Direction (address 3) reads all ones, which means every pin is an input. The output (1), polarity (2), style (4), drive (5), enable (6), status (7) and global (9) registers read zero. No pin is driven, and the interrupt line idles high because active-low is the default.
- R2: Address 8 returns the pin levels sampled while reset was held, and those levels do not change afterwards. Address 0 returns the current synchronised pin levels.
- R3: A level-style output pin (style bit 0, direction bit 0) carries the value output bit XOR polarity bit.
- R4: When the drive bit is 1 (push-pull), an output pin is always enabled and its data equals its value. When the drive bit is 0 (open-drain), the pin is enabled with data 0 only while its value is 0, and it is released while its value is 1.
- R5: For a pulse-style pin (style bit 1), writing a 1 to its output bit produces one active pulse lasting OUT_PULSE_NS of clock cycles. The active level is high when the polarity bit is 0 and low when it is 1. Outside the pulse, the pin rests at the opposite level.
- R6: Any edge on an input-mode pin sets that pin's status bit within 3 clock cycles, whether or not the pin's interrupt is enabled. Pins in output mode never set status bits.
- R7: A read of address 7 returns the status and then clears it. Without such a read, every set status bit stays set.
- R8: In level style (global bit 2 = 0), the interrupt line is active for as long as any status bit whose enable bit is 1 is set.
- R9: In pulse style (global bit 2 = 1), the interrupt line repeats pulses of IRQ_PULSE_NS width, with a period of twice that width, while an enabled status bit is pending. The line is quiet once the status has been read.
- R10: Global bit 3 = 1 makes the interrupt line active high. Global bit 3 = 0 makes it active low.
- R11: When wake enable (global bit 4) is set, an edge on an enabled input pin clears the low-power bit (global bit 5). An edge on a pin whose interrupt is not enabled leaves the low-power bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 7 clears the status |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data, combinational from reg_addr |
| pin_in | input | WIDTH | Pad input levels |
| pin_oe | output | WIDTH | Pad output enables |
| pin_do | output | WIDTH | Pad output data |
| irq_pin | output | 1 | Shared interrupt line |

## Verification
Each failure mode shows up at the ports within a few cycles. A status bit that is lost or set wrongly shows on the very next read of address 7, and in level style it also shows on the interrupt line within three cycles of the edge. A pulse counter that loads or decrements wrongly changes the number of active cycles that the bench counts on the pin or on the interrupt line inside a fixed window. A wrong pad enable or data bit under any mix of direction, polarity and drive shows on pin_oe or pin_do in the cycle after the configuration write.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int WIDTH        = 8,
  parameter int CLK_HZ       = 8_000_000,
  parameter int OUT_PULSE_NS = 500,
  parameter int IRQ_PULSE_NS = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_do,
  output logic             irq_pin
);
  localparam longint ORAW = (longint'(CLK_HZ) * OUT_PULSE_NS) / 1_000_000_000;
  localparam longint IRAW = (longint'(CLK_HZ) * IRQ_PULSE_NS) / 1_000_000_000;
  localparam int OCYC = (ORAW < 1) ? 1 : int'(ORAW);
  localparam int ICYC = (IRAW < 1) ? 1 : int'(IRAW);
  localparam int OW = $clog2(OCYC + 1);
  localparam int IW = $clog2(2 * ICYC + 1);

  localparam logic [3:0] A_IN = 4'd0, A_OUT = 4'd1, A_POL = 4'd2, A_DIR = 4'd3,
                         A_STY = 4'd4, A_DRV = 4'd5, A_IEN = 4'd6, A_STS = 4'd7,
                         A_SNAP = 4'd8, A_GCFG = 4'd9;

  logic [WIDTH-1:0] sync1, sync2, sync3;
  logic [WIDTH-1:0] out_r, pol_r, dir_r, sty_r, drv_r, ien_r, sts_r, snap_r;
  logic             irq_sty, irq_pol, wake_en, lowpwr;
  logic [OW-1:0]    pcnt [WIDTH];
  logic [IW-1:0]    icnt;
  logic [WIDTH-1:0] val, gcfg_rd;

  wire [WIDTH-1:0] edge_w = (sync2 ^ sync3) & dir_r;
  wire sts_hit = reg_rd && reg_addr == A_STS;
  wire pend    = |(sts_r & ien_r);
  wire wake    = wake_en && |(edge_w & ien_r);
  wire wr_out  = reg_wr && reg_addr == A_OUT;
  wire wr_gcfg = reg_wr && reg_addr == A_GCFG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= pin_in;
      sync2  <= pin_in;
      sync3  <= pin_in;
      snap_r <= pin_in;
      out_r  <= '0;
      pol_r  <= '0;
      dir_r  <= '1;
      sty_r  <= '0;
      drv_r  <= '0;
      ien_r  <= '0;
      sts_r  <= '0;
      irq_sty <= 1'b0;
      irq_pol <= 1'b0;
      wake_en <= 1'b0;
      lowpwr  <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      sync3 <= sync2;
      sts_r <= (sts_hit ? '0 : sts_r) | edge_w;
      if (reg_wr) begin
        case (reg_addr)
          A_OUT: out_r <= reg_wdata;
          A_POL: pol_r <= reg_wdata;
          A_DIR: dir_r <= reg_wdata;
          A_STY: sty_r <= reg_wdata;
          A_DRV: drv_r <= reg_wdata;
          A_IEN: ien_r <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_gcfg) begin
        irq_sty <= reg_wdata[2];
        irq_pol <= reg_wdata[3];
        wake_en <= reg_wdata[4];
      end
      if (wake)         lowpwr <= 1'b0;
      else if (wr_gcfg) lowpwr <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WIDTH; i++) begin
      if (!rst_n)                              pcnt[i] <= '0;
      else if (wr_out && reg_wdata[i] && sty_r[i]) pcnt[i] <= OW'(OCYC);
      else if (pcnt[i] != '0)                  pcnt[i] <= pcnt[i] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pend)               icnt <= '0;
    else if (icnt == IW'(2 * ICYC - 1)) icnt <= '0;
    else                               icnt <= icnt + 1'b1;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    assign val[g] = sty_r[g] ? (pol_r[g] ^ (pcnt[g] != '0)) : (out_r[g] ^ pol_r[g]);
  end

  assign pin_oe = ~dir_r & (drv_r | ~val);
  assign pin_do = val & drv_r;

  wire irq_act = pend && (!irq_sty || icnt < IW'(ICYC));
  assign irq_pin = irq_pol ? irq_act : !irq_act;

  always_comb begin
    gcfg_rd = '0;
    gcfg_rd[5:2] = {lowpwr, wake_en, irq_pol, irq_sty};
  end

  always_comb begin
    case (reg_addr)
      A_IN:    reg_rdata = sync2;
      A_OUT:   reg_rdata = out_r;
      A_POL:   reg_rdata = pol_r;
      A_DIR:   reg_rdata = dir_r;
      A_STY:   reg_rdata = sty_r;
      A_DRV:   reg_rdata = drv_r;
      A_IEN:   reg_rdata = ien_r;
      A_STS:   reg_rdata = sts_r;
      A_SNAP:  reg_rdata = snap_r;
      A_GCFG:  reg_rdata = gcfg_rd;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       reg_addr,
  input logic             reg_rd,
  input logic [WIDTH-1:0] dir_r,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] sts_r,
  input logic [WIDTH-1:0] ien_r,
  input logic [WIDTH-1:0] edge_w,
  input logic             irq_sty,
  input logic             irq_pol,
  input logic             irq_pin,
  input logic             wake_en,
  input logic             lowpwr
);
  assert_input_never_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_r) == '0);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == 4'd7) |=> (sts_r & $past(sts_r)) == $past(sts_r));

  assert_edge_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w != '0 |=> (sts_r & $past(edge_w)) == $past(edge_w));

  assert_level_irq_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_sty && (sts_r & ien_r) != '0) |-> irq_pin == irq_pol);

  assert_idle_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_r & ien_r) == '0 |-> irq_pin == !irq_pol);

  assert_wake_clears_lowpower_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && (edge_w & ien_r) != '0) |=> !lowpwr);
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .dir_r(dir_r), .pin_oe(pin_oe), .sts_r(sts_r), .ien_r(ien_r),
  .edge_w(edge_w), .irq_sty(irq_sty), .irq_pol(irq_pol), .irq_pin(irq_pin),
  .wake_en(wake_en), .lowpwr(lowpwr)
);

// File: tb/tb_gpio_bank_irq.sv
module tb_gpio_bank_irq;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int OC = 4;
  localparam int IC = 2;

  logic         clk = 0;
  logic         rst_n;
  logic [3:0]   reg_addr;
  logic         reg_wr, reg_rd;
  logic [W-1:0] reg_wdata, reg_rdata, pin_in, pin_oe, pin_do;
  logic         irq_pin;

  int checks = 0, errors = 0;

  gpio_bank_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_do(pin_do), .irq_pin(irq_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_oe(logic [W-1:0] o, p, d, dv);
    return ~d & (dv | ~(o ^ p));
  endfunction

  function automatic logic [W-1:0] exp_do(logic [W-1:0] o, p, dv);
    return (o ^ p) & dv;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] d, o, p, dr, dv, ien, expst, flip;
    int cnt;
    void'($urandom(32'd1234));
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0; pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(4'd3, d); check("R1 dir reset", d, 8'hFF);
    rd(4'd1, d); check("R1 out reset", d, 0);
    rd(4'd9, d); check("R1 global reset", d, 0);
    rd(4'd7, d); check("R1 status reset", d, 0);
    check("R1 no drive", pin_oe, 0);
    check("R1 irq idle", irq_pin, 1);

    rd(4'd8, d); check("R2 snapshot", d, 8'hA5);
    @(negedge clk); pin_in = 8'h3C; settle();
    rd(4'd0, d); check("R2 live input", d, 8'h3C);
    rd(4'd8, d); check("R2 snapshot held", d, 8'hA5);
    rd(4'd7, d); check("R6 status edges", d, 8'h99);
    rd(4'd7, d); check("R7 read clears", d, 0);

    for (int k = 0; k < 24; k++) begin
      o = 8'($urandom); p = 8'($urandom); dr = 8'($urandom); dv = 8'($urandom);
      wr(4'd1, o); wr(4'd2, p); wr(4'd5, dv); wr(4'd3, dr);
      check("R3 level oe", pin_oe, exp_oe(o, p, dr, dv));
      check("R4 drive data", pin_do, exp_do(o, p, dv));
    end
    wr(4'd3, 8'h00); wr(4'd5, 8'h00); wr(4'd2, 8'h00); wr(4'd1, 8'h00);
    check("R4 open-drain low driven", pin_oe, 8'hFF);
    wr(4'd1, 8'hFF);
    check("R4 open-drain high released", pin_oe, 8'h00);

    wr(4'd1, 8'h00); wr(4'd5, 8'hFF); wr(4'd4, 8'h03); wr(4'd2, 8'h02);
    check("R5 rest levels", pin_do[1:0], 2'b10);
    wr(4'd1, 8'h01);
    cnt = 0;
    for (int k = 0; k < OC + 3; k++) begin cnt += pin_do[0]; @(negedge clk); end
    check("R5 pulse high width", cnt, OC);
    wr(4'd1, 8'h02);
    cnt = 0;
    for (int k = 0; k < OC + 3; k++) begin cnt += !pin_do[1]; @(negedge clk); end
    check("R5 pulse low width", cnt, OC);
    check("R5 back to rest", pin_do[1:0], 2'b10);
    wr(4'd1, 8'h00); wr(4'd4, 8'h00); wr(4'd2, 8'h00);

    wr(4'd3, 8'hF0);
    rd(4'd7, d);
    @(negedge clk); pin_in = pin_in ^ 8'h0F; settle();
    rd(4'd7, d); check("R6 output pins no status", d, 0);
    wr(4'd3, 8'hFF);

    wr(4'd6, 8'h08); wr(4'd9, 8'h00);
    @(negedge clk); pin_in[2] = ~pin_in[2]; settle();
    check("R8 disabled pin no irq", irq_pin, 1);
    rd(4'd7, d); check("R6 disabled pin status", d, 8'h04);
    @(negedge clk); pin_in[3] = ~pin_in[3]; settle();
    check("R8 level irq active", irq_pin, 0);
    repeat (10) @(negedge clk);
    check("R7 level irq held", irq_pin, 0);
    rd(4'd7, d); check("R7 status read", d, 8'h08);
    check("R8 irq released", irq_pin, 1);

    wr(4'd9, 8'h08);
    check("R10 active-high idle", irq_pin, 0);
    @(negedge clk); pin_in[3] = ~pin_in[3]; settle();
    check("R10 active-high asserted", irq_pin, 1);
    rd(4'd7, d);

    wr(4'd9, 8'h0C);
    @(negedge clk); pin_in[3] = ~pin_in[3]; settle();
    cnt = 0;
    for (int k = 0; k < 4 * IC; k++) begin cnt += irq_pin; @(negedge clk); end
    check("R9 repeated pulses", cnt, 2 * IC);
    rd(4'd7, d);
    cnt = 0;
    for (int k = 0; k < 4 * IC; k++) begin cnt += irq_pin; @(negedge clk); end
    check("R9 quiet after read", cnt, 0);

    wr(4'd9, 8'h30);
    rd(4'd9, d); check("R11 lowpower set", d, 8'h30);
    @(negedge clk); pin_in[2] = ~pin_in[2]; settle();
    rd(4'd9, d); check("R11 disabled pin no wake", d, 8'h30);
    @(negedge clk); pin_in[3] = ~pin_in[3]; settle();
    rd(4'd9, d); check("R11 wake cleared", d, 8'h10);
    rd(4'd7, d);

    wr(4'd9, 8'h00);
    expst = 0; ien = 0;
    for (int k = 0; k < 30; k++) begin
      if (k % 6 == 0) begin ien = 8'($urandom); wr(4'd6, ien); end
      flip = 8'($urandom);
      @(negedge clk); pin_in = pin_in ^ flip; settle();
      expst |= flip;
      check("R8 random irq", irq_pin, !((expst & ien) != 0));
      if (k % 3 == 2) begin
        rd(4'd7, d); check("R6 random status", d, expst);
        expst = 0;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule